// File: doc/BRIEF.md
# Paged Command and Interrupt Register Block for an Ethernet Controller

This block is the host-facing control front end of a small Ethernet controller. A host talks to it through a byte-wide register port. The port has a 4-bit offset and separate read and write strobes. Offset 0 always holds the command byte. The top two bits of the command byte choose which register page the other fifteen offsets reach. The other command fields start and stop the controller, request a frame transmission, and carry a 3-bit remote DMA command. The block drives these fields out to the rest of the controller.

The block also keeps an 8-bit interrupt status register and an 8-bit interrupt mask register. It drives one level interrupt line. Other blocks signal events with one-cycle pulses on `evt_i`, and each pulse sets the matching status bit. The host clears a status bit by writing a 1 to it.

Page 1 holds the six-byte station address and the current-page pointer of the receive ring. On page 0, one offset can reach a different register for a read than for a write. Offset 0x0C returns the receive status input on a read, but a write to it stores the receive configuration byte. Page 2 reads back the write-only page-0 registers. The host-side port is a plain strobe interface: reads are combinational and writes take effect at the next clock edge. It has no valid/ready stream.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After reset the command byte reads 0x21: stop bit 0 is 1, start bit 1 is 0, transmit bit 2 is 0, remote DMA field bits 5:3 is 100 (abort), and page bits 7:6 are 00. The interrupt status reads 0x80 (reset-status bit 7 set). The interrupt mask reads 0x00.
- R2: The command byte is written and read at offset 0 on every page. Its bits 7:6 select the page: 00 is page 0, 01 is page 1, 10 is page 2. `page_o`, `start_o` and `stop_o` follow the written fields one cycle after the write.
- R3: Writing 1 to command bit 2 sets the transmit request. Writing 0 to it leaves the request unchanged. A `tx_done_i` pulse clears the request. A write of 1 in the same cycle as `tx_done_i` leaves the request set.
- R4: Command bits 5:3 appear on `rdma_cmd_o` and read back unchanged. The codes are 001 remote read, 010 remote write, 011 send packet, and 1xx abort/complete.
- R5: Each `evt_i` bit pulsed in a cycle sets the matching interrupt status bit. The layout is: bit 0 rx ok, bit 1 tx ok, bit 2 rx error, bit 3 tx error, bit 4 ring overwrite warning, bit 5 counter overflow, bit 6 remote DMA done, bit 7 reset status. The status is readable at page 0 offset 0x07.
- R6: A page-0 write to offset 0x07 clears every status bit written as 1. Bits written as 0 keep their value.
- R7: If an event pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both 1. The mask is written at page 0 offset 0x0F and read back at page 2 offset 0x0F.
- R9: At page 0 offset 0x0C, a read returns `rx_status_i` and a write stores the receive configuration byte. That byte drives `rx_cfg_o` and reads back at page 2 offset 0x0C.
- R10: On page 1, offsets 0x01 to 0x06 read and write station address bytes 0 to 5. Byte 0 drives `station_addr_o[7:0]`. Offset 0x07 reads and writes the current-page pointer, which drives `cur_page_o`.
- R11: On pages 2 and 3, writes to any offset other than 0 have no effect. Reads of unmapped offsets return 0x00, and all reads return 0x00 while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational) |
| evt_i | input | 8 | One-cycle event pulses, one per status bit |
| tx_done_i | input | 1 | Transmit finished pulse |
| rx_status_i | input | 8 | Receive status byte from the MAC |
| irq_o | output | 1 | Interrupt request |
| page_o | output | 2 | Selected register page |
| start_o | output | 1 | Start command bit |
| stop_o | output | 1 | Stop command bit |
| tx_req_o | output | 1 | Pending transmit request |
| rdma_cmd_o | output | 3 | Remote DMA command field |
| rx_cfg_o | output | 8 | Receive configuration byte |
| station_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |
| cur_page_o | output | 8 | Current receive ring page |

## Verification
Two pairs of actions can land on the same clock edge. One pair is a host write-1-to-clear of a status bit and an event pulse on that bit. The other pair is a host write that sets the transmit request and a transmit-done pulse. The bench provokes each by raising the event or done input in the same cycle as the write strobe. It then reads the status register, or samples `tx_req_o`, one cycle later. The event or the new request must win. Table rows mix clears that overlap events with clears that do not, so both outcomes are judged in one run.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int DW     = 8;
  localparam int AW     = 4;
  localparam int NSTN   = 6;

  typedef enum logic [1:0] {PG0 = 2'd0, PG1 = 2'd1, PG2 = 2'd2, PG3 = 2'd3} page_e;

  localparam logic [AW-1:0] OFF_CMD   = 4'h0;
  localparam logic [AW-1:0] OFF_ISR   = 4'h7;
  localparam logic [AW-1:0] OFF_RXREG = 4'hC;
  localparam logic [AW-1:0] OFF_IMR   = 4'hF;
  localparam logic [AW-1:0] OFF_CURP  = 4'h7;

  localparam int CMD_STOP  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_TX    = 2;
  localparam int CMD_RD_LO = 3;
  localparam int CMD_PG_LO = 6;

  localparam logic [DW-1:0] CMD_RESET = 8'h21;
  localparam logic [DW-1:0] ISR_RESET = 8'h80;
endpackage

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
  import nic_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          tx_done,
  output logic [DW-1:0] cmd_q
);
  logic tx_q;
  logic [DW-1:0] fields_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= CMD_RESET;
      tx_q     <= 1'b0;
    end else begin
      if (we) fields_q <= wdata;
      // a fresh request written this cycle outranks a completion
      if (we && wdata[CMD_TX]) tx_q <= 1'b1;
      else if (tx_done)        tx_q <= 1'b0;
    end
  end

  always_comb begin
    cmd_q         = fields_q;
    cmd_q[CMD_TX] = tx_q;
  end
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit #(
  parameter int NBIT = 8,
  parameter logic [NBIT-1:0] STAT_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBIT-1:0] evt,
  input  logic            clr_we,
  input  logic [NBIT-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NBIT-1:0] mask_d,
  output logic [NBIT-1:0] stat_q,
  output logic [NBIT-1:0] mask_q,
  output logic            irq
);
  logic [NBIT-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_eff) | evt;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/nic_stn_regs.sv
module nic_stn_regs #(
  parameter int NBYTES = 6,
  parameter int DW     = 8,
  parameter int IW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  logic [DW-1:0]        wdata,
  output logic [NBYTES*DW-1:0] bytes_q
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                         bytes_q[g*DW +: DW] <= '0;
      else if (we && idx == IW'(g))       bytes_q[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         addr_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  input  logic               rd_i,
  output logic [7:0]         rdata_o,
  input  logic [7:0]         evt_i,
  input  logic               tx_done_i,
  input  logic [7:0]         rx_status_i,
  output logic               irq_o,
  output logic [1:0]         page_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               tx_req_o,
  output logic [2:0]         rdma_cmd_o,
  output logic [7:0]         rx_cfg_o,
  output logic [47:0]        station_addr_o,
  output logic [7:0]         cur_page_o
);
  localparam int IW = $clog2(NSTN + 1);

  logic [DW-1:0] cmd_val, isr_val, imr_val, rxcfg_q, curp_q;
  page_e         pg;
  logic          at_cmd, wr_cmd, wr_isr, wr_imr, wr_rxcfg, wr_stn, wr_curp;
  logic          stn_hit;
  logic [IW-1:0] stn_idx;

  assign pg      = page_e'(cmd_val[CMD_PG_LO +: 2]);
  assign at_cmd  = (addr_i == OFF_CMD);
  assign stn_hit = (addr_i != OFF_CMD) && (int'(addr_i) <= NSTN);
  assign stn_idx = IW'(addr_i - 4'd1);

  assign wr_cmd   = wr_i && at_cmd;
  assign wr_isr   = wr_i && pg == PG0 && addr_i == OFF_ISR;
  assign wr_imr   = wr_i && pg == PG0 && addr_i == OFF_IMR;
  assign wr_rxcfg = wr_i && pg == PG0 && addr_i == OFF_RXREG;
  assign wr_stn   = wr_i && pg == PG1 && stn_hit;
  assign wr_curp  = wr_i && pg == PG1 && addr_i == OFF_CURP;

  nic_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .we(wr_cmd), .wdata(wdata_i),
    .tx_done(tx_done_i), .cmd_q(cmd_val)
  );

  nic_irq_unit #(.NBIT(DW), .STAT_RST(ISR_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_i),
    .clr_we(wr_isr), .clr_bits(wdata_i),
    .mask_we(wr_imr), .mask_d(wdata_i),
    .stat_q(isr_val), .mask_q(imr_val), .irq(irq_o)
  );

  nic_stn_regs #(.NBYTES(NSTN), .DW(DW), .IW(IW)) u_stn (
    .clk(clk), .rst_n(rst_n), .we(wr_stn), .idx(stn_idx),
    .wdata(wdata_i), .bytes_q(station_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxcfg_q <= '0;
      curp_q  <= '0;
    end else begin
      if (wr_rxcfg) rxcfg_q <= wdata_i;
      if (wr_curp)  curp_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (at_cmd) rdata_o = cmd_val;
      else begin
        unique case (pg)
          PG0: begin
            if (addr_i == OFF_ISR)        rdata_o = isr_val;
            else if (addr_i == OFF_RXREG) rdata_o = rx_status_i;
          end
          PG1: begin
            if (stn_hit)                  rdata_o = station_addr_o[int'(stn_idx)*DW +: DW];
            else if (addr_i == OFF_CURP)  rdata_o = curp_q;
          end
          PG2: begin
            if (addr_i == OFF_IMR)        rdata_o = imr_val;
            else if (addr_i == OFF_RXREG) rdata_o = rxcfg_q;
          end
          default: rdata_o = '0;
        endcase
      end
    end
  end

  assign page_o     = cmd_val[CMD_PG_LO +: 2];
  assign start_o    = cmd_val[CMD_START];
  assign stop_o     = cmd_val[CMD_STOP];
  assign tx_req_o   = cmd_val[CMD_TX];
  assign rdma_cmd_o = cmd_val[CMD_RD_LO +: 3];
  assign rx_cfg_o   = rxcfg_q;
  assign cur_page_o = curp_q;
endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] evt_i,
  input logic       tx_done_i,
  input logic       tx_req_o,
  input logic       irq_o,
  input logic [1:0] page_o,
  input logic [7:0] rx_cfg_o,
  input logic [7:0] isr_val,
  input logic [7:0] imr_val
);
  a_r5_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((isr_val & $past(evt_i)) == $past(evt_i)));

  a_r6_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && page_o == 2'd0 && addr_i == 4'h7 && evt_i == 8'h00)
      |=> ((isr_val & $past(wdata_i)) == 8'h00));

  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_i && !(wr_i && addr_i == 4'h0 && wdata_i[2])) |=> !tx_req_o);

  a_r2_page_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 4'h0) |=> (page_o == $past(wdata_i[7:6])));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_val == 8'h00) |-> !irq_o);

  a_r11_upper_pages_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && page_o[1] && addr_i != 4'h0) |=> ($stable(imr_val) && $stable(rx_cfg_o)));
endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .evt_i(evt_i), .tx_done_i(tx_done_i), .tx_req_o(tx_req_o), .irq_o(irq_o),
  .page_o(page_o), .rx_cfg_o(rx_cfg_o), .isr_val(isr_val), .imr_val(imr_val)
);

// File: tb/tb_nic_ctrl_regs.sv
module tb_nic_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr_i;
  logic        wr_i, rd_i, tx_done_i;
  logic [7:0]  wdata_i, rdata_o, evt_i, rx_status_i, rx_cfg_o, cur_page_o;
  logic        irq_o, start_o, stop_o, tx_req_o;
  logic [1:0]  page_o;
  logic [2:0]  rdma_cmd_o;
  logic [47:0] station_addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .evt_i(evt_i), .tx_done_i(tx_done_i),
    .rx_status_i(rx_status_i), .irq_o(irq_o), .page_o(page_o), .start_o(start_o),
    .stop_o(stop_o), .tx_req_o(tx_req_o), .rdma_cmd_o(rdma_cmd_o), .rx_cfg_o(rx_cfg_o),
    .station_addr_o(station_addr_o), .cur_page_o(cur_page_o)
  );

  // set events, clear mask, simultaneous events, irq mask, expected status, expected irq
  typedef struct packed {
    logic [7:0] set_ev;
    logic [7:0] clr;
    logic [7:0] sim_ev;
    logic [7:0] mask;
    logic [7:0] exp_isr;
    logic       exp_irq;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1},
    '{8'h03, 8'h01, 8'h00, 8'h01, 8'h02, 1'b0},
    '{8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 1'b1},
    '{8'h0F, 8'hF0, 8'h10, 8'h20, 8'h1F, 1'b0},
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d,
                    input logic [7:0] ev = 8'h00, input logic done_p = 1'b0);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1; evt_i = ev; tx_done_i = done_p;
    @(negedge clk);
    wr_i = 1'b0; evt_i = 8'h00; tx_done_i = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = 8'h00;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; addr_i = '0; wr_i = 1'b0; rd_i = 1'b0; wdata_i = '0;
    evt_i = '0; tx_done_i = 1'b0; rx_status_i = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, r); check("R1 cmd", r, 8'h21);
    rd(4'h7, r); check("R1 isr", r, 8'h80);
    check("R1 irq", irq_o, 1'b0);
    wr(4'h0, 8'h80); rd(4'hF, r); check("R1 imr", r, 8'h00);
    wr(4'h0, 8'h22);

    // R5 R6 R7 R8 table
    for (int i = 0; i < NVEC; i++) begin
      wr(4'hF, 8'h00);
      wr(4'h7, 8'hFF);
      pulse_evt(VECS[i].set_ev);
      wr(4'h7, VECS[i].clr, VECS[i].sim_ev);
      wr(4'hF, VECS[i].mask);
      rd(4'h7, r);
      check("R5/R6/R7 isr", r, VECS[i].exp_isr);
      check("R8 irq", irq_o, VECS[i].exp_irq);
    end
    wr(4'hF, 8'h00); wr(4'h7, 8'hFF);

    // R2 page select through offset 0
    wr(4'h0, 8'h41);
    check("R2 page1", page_o, 2'd1);
    check("R2 stop", stop_o, 1'b1);
    rd(4'h0, r); check("R2 cmd page1", r, 8'h41);

    // R10 station address and current page on page 1
    for (int k = 1; k <= 6; k++) wr(4'(k), 8'(8'h10 + k));
    wr(4'h7, 8'h4C);
    rd(4'h3, r); check("R10 byte2", r, 8'h13);
    check("R10 station", station_addr_o, 48'h161514131211);
    check("R10 curp", cur_page_o, 8'h4C);
    rd(4'h7, r); check("R10 curp read", r, 8'h4C);
    rd(4'h9, r); check("R11 unmapped p1", r, 8'h00);

    // R9 split read/write at 0x0C on page 0
    wr(4'h0, 8'h22);
    check("R2 start", start_o, 1'b1);
    wr(4'h0C, 8'h5A);
    check("R9 cfg out", rx_cfg_o, 8'h5A);
    rd(4'hC, r); check("R9 read status", r, 8'hA5);
    wr(4'hF, 8'h3C);
    wr(4'h0, 8'h82);
    rd(4'hC, r); check("R9 cfg readback", r, 8'h5A);
    rd(4'hF, r); check("R8 imr readback", r, 8'h3C);

    // R11 page 2 writes ignored
    wr(4'hF, 8'h33); wr(4'hC, 8'h77);
    rd(4'hF, r); check("R11 imr kept", r, 8'h3C);
    check("R11 cfg kept", rx_cfg_o, 8'h5A);
    @(negedge clk); addr_i = 4'h0; rd_i = 1'b0; #1;
    check("R11 idle read", rdata_o, 8'h00);

    // R3 transmit bit
    wr(4'h0, 8'h26);
    check("R3 set", tx_req_o, 1'b1);
    rd(4'h0, r); check("R3 cmd read", r, 8'h26);
    wr(4'h0, 8'h22);
    check("R3 write0 keeps", tx_req_o, 1'b1);
    @(negedge clk); tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
    check("R3 done clears", tx_req_o, 1'b0);
    wr(4'h0, 8'h26, 8'h00, 1'b1);
    check("R3 write wins", tx_req_o, 1'b1);

    // R4 remote DMA field
    wr(4'h0, 8'h0A); check("R4 read", rdma_cmd_o, 3'b001);
    wr(4'h0, 8'h12); check("R4 write", rdma_cmd_o, 3'b010);
    wr(4'h0, 8'h1A); check("R4 send", rdma_cmd_o, 3'b011);
    rd(4'h0, r); check("R4 readback", r[5:3], 3'b011);
    wr(4'h0, 8'h22); check("R4 abort", rdma_cmd_o, 3'b100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule